// File: doc/BRIEF.md
# Circular Ping-Pong Address Generator

This block produces word addresses for an endless streaming transfer over a contiguous buffer, such as an audio ring. A configuration load captures a base word address and a region length in words. From then on, each accepted beat on a valid/ready handshake advances the address by one word. After the last word of the region, the address returns to the base and the sweep starts again.

The region is split into two equal halves, a first half and a second half. A one-cycle interrupt pulse fires when the last word of either half has been accepted, so software can refill one half while the engine streams the other. A flag beside the pulse tells the two halves apart, and a free-running event counter records every pulse.

Streaming needs two loop-enable inputs, and both must be high. If either one is low, the generator pauses: it keeps its position and fires no interrupts. When both are set again, it resumes from the word it was holding.

Top module: `pingpong_addr_gen`

## Requirements
- R1: While reset is asserted and directly after it, addrValid, halfIrq and cfgErr are 0 and evtCount is 0.
- R2: A cycle with loadCfg high captures baseIn and sizeIn and sets the position to word 0. In the next cycle addrOut equals baseIn. A load with a non-zero even size clears cfgErr.
- R3: A load whose size is zero or odd sets cfgErr to 1. addrValid then stays 0 until a later load with a valid size, whatever the enables and addrReady do.
- R4: addrValid is 1 exactly when the last load had a valid size and both loopEnA and loopEnB are 1. With only one enable high, addrValid is 0.
- R5: Each beat with addrValid and addrReady high, and loadCfg low, advances addrOut by one word. After the beat at offset size-1, addrOut returns to the base, so after N beats from a load addrOut equals base + (N mod size).
- R6: In the cycle after the beat at offset size/2-1 is accepted, halfIrq is 1 for one cycle with halfIsB = 0.
- R7: In the cycle after the beat at offset size-1 is accepted, halfIrq is 1 for one cycle with halfIsB = 1. With a two-word region, every beat produces a pulse, and the halves alternate.
- R8: While paused (either enable low), addrOut is held, halfIrq stays 0 and evtCount does not change, even with addrReady high. After both enables are set again, streaming continues from the held address.
- R9: evtCount increases by exactly one in each cycle in which halfIrq is 1 and stays unchanged otherwise. It wraps modulo 2^CNT_W.
- R10: When loadCfg coincides with an accepted beat, the load takes effect: no interrupt follows, and in the next cycle addrOut equals the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadCfg | input | 1 | Capture baseIn and sizeIn and restart at word 0 |
| baseIn | input | ADDR_W | Region base word address |
| sizeIn | input | SIZE_W | Region length in words, must be even and non-zero |
| loopEnA | input | 1 | First loop enable |
| loopEnB | input | 1 | Second loop enable |
| addrReady | input | 1 | Consumer accepts the offered address |
| addrValid | output | 1 | An address is offered |
| addrOut | output | ADDR_W | Current word address |
| halfIrq | output | 1 | One-cycle pulse at the end of a half |
| halfIsB | output | 1 | 1 if the pulse marks the end of the second half |
| evtCount | output | CNT_W | Count of half-end pulses |
| cfgErr | output | 1 | Last load had an invalid size |

## Verification
Two functions can fall in the same cycle: a configuration load and the acceptance of a beat, at the very word that would close the region. The bench provokes this by holding addrReady high while it pulses loadCfg. It then judges the next cycle: halfIrq must stay low, evtCount must not move, and addrOut must show the new base. The pause path is checked in a similar way: addrReady stays high through the pause, and the held address and the frozen counter are compared.

// File: rtl/pingpong_pkg.sv
package pingpong_pkg;

  // strobes from the loop controller to the address datapath
  typedef struct packed {
    logic load;    // capture configuration, restart at word 0
    logic step;    // accepted beat, not at region end
    logic wrap;    // accepted beat at region end, back to base
    logic midHit;  // accepted beat is the last of the first half
    logic endHit;  // accepted beat is the last of the second half
  } ctrlStrb_t;

  // position flags from the datapath back to the controller
  typedef struct packed {
    logic atMid;
    logic atEnd;
  } dpFlags_t;

endpackage

// File: rtl/pp_loop_ctrl.sv
module pp_loop_ctrl
  import pingpong_pkg::*;
#(
  parameter int SIZE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadCfg,
  input  logic [SIZE_W-1:0] sizeIn,
  input  logic              loopEnA,
  input  logic              loopEnB,
  input  logic              addrReady,
  input  dpFlags_t          flags,
  output ctrlStrb_t         strb,
  output logic              addrValid,
  output logic              cfgErr
);

  logic armed;
  logic sizeOk;
  logic running;
  logic fire;

  // a region must hold a non-zero even number of words
  assign sizeOk = (sizeIn != '0) && !sizeIn[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed  <= 1'b0;
      cfgErr <= 1'b0;
    end else if (loadCfg) begin
      armed  <= sizeOk;
      cfgErr <= !sizeOk;
    end
  end

  assign running   = armed && loopEnA && loopEnB;
  assign addrValid = running;

  // a load in the same cycle as a beat wins; the beat is dropped
  assign fire = running && addrReady && !loadCfg;

  always_comb begin
    strb        = '0;
    strb.load   = loadCfg;
    strb.step   = fire && !flags.atEnd;
    strb.wrap   = fire && flags.atEnd;
    strb.midHit = fire && flags.atMid;
    strb.endHit = fire && flags.atEnd;
  end

  // R3: an odd size is refused and keeps the stream stopped
  p_reject_odd_r3: assert property (@(posedge clk) disable iff (!rstN)
    (loadCfg && sizeIn[0]) |=> (cfgErr && !addrValid));

  // R4: no offer unless both enables were high
  p_need_both_en_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!loopEnA || !loopEnB) |-> !addrValid);

endmodule

// File: rtl/pp_addr_datapath.sv
module pp_addr_datapath
  import pingpong_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [ADDR_W-1:0] baseIn,
  input  logic [SIZE_W-1:0] sizeIn,
  output dpFlags_t          flags,
  output logic [ADDR_W-1:0] addrOut,
  output logic              halfIrq,
  output logic              halfIsB,
  output logic [CNT_W-1:0]  evtCount
);

  logic [ADDR_W-1:0] baseReg;
  logic [SIZE_W-1:0] sizeReg;
  logic [SIZE_W-1:0] offset;
  logic [SIZE_W-1:0] midIdx;
  logic [SIZE_W-1:0] endIdx;
  logic              anyHit;

  assign midIdx = (sizeReg >> 1) - SIZE_W'(1);
  assign endIdx = sizeReg - SIZE_W'(1);

  assign flags.atMid = (offset == midIdx);
  assign flags.atEnd = (offset == endIdx);

  assign addrOut = baseReg + ADDR_W'(offset);
  assign anyHit  = strb.midHit || strb.endHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseReg <= '0;
      sizeReg <= '0;
      offset  <= '0;
    end else if (strb.load) begin
      baseReg <= baseIn;
      sizeReg <= sizeIn;
      offset  <= '0;
    end else if (strb.wrap) begin
      offset  <= '0;
    end else if (strb.step) begin
      offset  <= offset + SIZE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfIrq  <= 1'b0;
      halfIsB  <= 1'b0;
      evtCount <= '0;
    end else begin
      halfIrq <= anyHit;
      halfIsB <= strb.endHit;
      if (anyHit) evtCount <= evtCount + CNT_W'(1);
    end
  end

  // R5: the position never leaves the configured region
  p_offset_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sizeReg != '0) |-> (offset < sizeReg));

  // R7: the two half boundaries are never claimed by one beat
  p_halves_exclusive_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.midHit && strb.endHit));

endmodule

// File: rtl/pingpong_addr_gen.sv
module pingpong_addr_gen
  import pingpong_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadCfg,
  input  logic [ADDR_W-1:0] baseIn,
  input  logic [SIZE_W-1:0] sizeIn,
  input  logic              loopEnA,
  input  logic              loopEnB,
  input  logic              addrReady,
  output logic              addrValid,
  output logic [ADDR_W-1:0] addrOut,
  output logic              halfIrq,
  output logic              halfIsB,
  output logic [CNT_W-1:0]  evtCount,
  output logic              cfgErr
);

  ctrlStrb_t strb;
  dpFlags_t  flags;

  pp_loop_ctrl #(.SIZE_W(SIZE_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .loadCfg  (loadCfg),
    .sizeIn   (sizeIn),
    .loopEnA  (loopEnA),
    .loopEnB  (loopEnB),
    .addrReady(addrReady),
    .flags    (flags),
    .strb     (strb),
    .addrValid(addrValid),
    .cfgErr   (cfgErr)
  );

  pp_addr_datapath #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .baseIn  (baseIn),
    .sizeIn  (sizeIn),
    .flags   (flags),
    .addrOut (addrOut),
    .halfIrq (halfIrq),
    .halfIsB (halfIsB),
    .evtCount(evtCount)
  );

  // R6: a pulse only ever follows an accepted beat
  p_irq_after_beat_r6: assert property (@(posedge clk) disable iff (!rstN)
    halfIrq |-> $past(addrValid && addrReady && !loadCfg));

  // R8: with nothing offered and nothing loaded, the address holds
  p_hold_paused_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(addrValid) && !$past(loadCfg)) |-> $stable(addrOut));

  // R9: the counter moves in step with the pulse
  p_count_follows_irq_r9: assert property (@(posedge clk) disable iff (!rstN)
    evtCount == CNT_W'($past(evtCount) + CNT_W'(halfIrq)));

  // R10: a load never produces an interrupt
  p_load_no_irq_r10: assert property (@(posedge clk) disable iff (!rstN)
    $past(loadCfg) |-> !halfIrq);

endmodule

// File: tb/pingpong_addr_gen_tb.sv
`timescale 1ns/100ps
module pingpong_addr_gen_tb;

  localparam int ADDR_W = 32;
  localparam int SIZE_W = 16;
  localparam int CNT_W  = 16;

  typedef struct packed {
    logic [31:0] base;
    logic [15:0] size;
    logic [15:0] beats;
    logic [7:0]  nA;
    logic [7:0]  nB;
    logic [15:0] endOff;
  } vec_t;

  // stimulus and expected pulse counts / final offset
  localparam int NVEC = 4;
  localparam vec_t VECS [NVEC] = '{
    '{32'd100,    16'd8,  16'd20, 8'd3, 8'd2, 16'd4},
    '{32'h2000,   16'd2,  16'd7,  8'd4, 8'd3, 16'd1},
    '{32'd50,     16'd16, 16'd16, 8'd1, 8'd1, 16'd0},
    '{32'd7,      16'd6,  16'd13, 8'd2, 8'd2, 16'd1}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              loadCfg = 1'b0;
  logic [ADDR_W-1:0] baseIn = '0;
  logic [SIZE_W-1:0] sizeIn = '0;
  logic              loopEnA = 1'b0;
  logic              loopEnB = 1'b0;
  logic              addrReady = 1'b0;
  logic              addrValid;
  logic [ADDR_W-1:0] addrOut;
  logic              halfIrq;
  logic              halfIsB;
  logic [CNT_W-1:0]  evtCount;
  logic              cfgErr;

  int total = 0;
  int bad = 0;
  int expEvt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pingpong_addr_gen #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .loadCfg(loadCfg), .baseIn(baseIn), .sizeIn(sizeIn),
    .loopEnA(loopEnA), .loopEnB(loopEnB), .addrReady(addrReady),
    .addrValid(addrValid), .addrOut(addrOut), .halfIrq(halfIrq), .halfIsB(halfIsB),
    .evtCount(evtCount), .cfgErr(cfgErr)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one-cycle configuration load, entered and left at a falling edge
  task automatic doLoad(input logic [31:0] b, input logic [15:0] s);
    baseIn  = b;
    sizeIn  = s;
    loadCfg = 1'b1;
    @(posedge clk);
    @(negedge clk);
    loadCfg = 1'b0;
  endtask

  // n beats with ready held high; checks each address and pulse
  task automatic runBeats(input logic [31:0] b, input int s, input int startOff,
                          input int n, output int cntA, output int cntB);
    int prevM;
    cntA = 0;
    cntB = 0;
    prevM = 0;
    addrReady = 1'b1;
    for (int k = 0; k <= n; k++) begin
      if (k > 0) begin
        logic expA;
        logic expB;
        expA = (prevM == s/2 - 1);
        expB = (prevM == s - 1);
        chk("R6/R7 halfIrq", 64'(halfIrq), 64'(expA || expB));
        if (expA || expB) begin
          chk("R6/R7 halfIsB", 64'(halfIsB), 64'(expB));
          expEvt++;
        end
        if (halfIrq && !halfIsB) cntA++;
        if (halfIrq && halfIsB) cntB++;
      end
      if (k < n) begin
        prevM = (startOff + k) % s;
        chk("R5 beat address", 64'(addrOut), 64'(b + 32'(prevM)));
        @(posedge clk);
        @(negedge clk);
      end
    end
    addrReady = 1'b0;
  endtask

  initial begin
    int cA;
    int cB;
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1 valid in reset", 64'(addrValid), 64'd0);
    chk("R1 irq in reset", 64'(halfIrq), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 valid", 64'(addrValid), 64'd0);
    chk("R1 irq", 64'(halfIrq), 64'd0);
    chk("R1 count", 64'(evtCount), 64'd0);
    chk("R1 cfgErr", 64'(cfgErr), 64'd0);

    loopEnA = 1'b1;
    loopEnB = 1'b1;

    // table walk: R2, R5, R6, R7, R9
    for (int v = 0; v < NVEC; v++) begin
      doLoad(VECS[v].base, VECS[v].size);
      chk("R2 base after load", 64'(addrOut), 64'(VECS[v].base));
      chk("R2 cfgErr clear", 64'(cfgErr), 64'd0);
      chk("R4 valid with both enables", 64'(addrValid), 64'd1);
      runBeats(VECS[v].base, int'(VECS[v].size), 0, int'(VECS[v].beats), cA, cB);
      chk("R6 first-half pulses", 64'(cA), 64'(VECS[v].nA));
      chk("R7 second-half pulses", 64'(cB), 64'(VECS[v].nB));
      chk("R5 final address", 64'(addrOut), 64'(VECS[v].base + 32'(VECS[v].endOff)));
      chk("R9 event count", 64'(evtCount), 64'(expEvt));
    end

    // R3: odd and zero sizes refused
    doLoad(32'h500, 16'd5);
    chk("R3 odd cfgErr", 64'(cfgErr), 64'd1);
    chk("R3 odd valid", 64'(addrValid), 64'd0);
    addrReady = 1'b1;
    repeat (3) @(negedge clk);
    addrReady = 1'b0;
    chk("R3 odd no pulse", 64'(halfIrq), 64'd0);
    chk("R3 odd count frozen", 64'(evtCount), 64'(expEvt));
    doLoad(32'h500, 16'd0);
    chk("R3 zero cfgErr", 64'(cfgErr), 64'd1);
    chk("R3 zero valid", 64'(addrValid), 64'd0);
    doLoad(32'h600, 16'd2);
    chk("R2 valid load clears cfgErr", 64'(cfgErr), 64'd0);
    chk("R2 valid load offers", 64'(addrValid), 64'd1);

    // R4 / R8: pause with one enable low, then resume
    doLoad(32'h40, 16'd8);
    runBeats(32'h40, 8, 0, 3, cA, cB);
    chk("R8 position before pause", 64'(addrOut), 64'h43);
    loopEnB = 1'b0;
    addrReady = 1'b1;
    @(negedge clk);
    chk("R4 one enable low", 64'(addrValid), 64'd0);
    repeat (4) @(negedge clk);
    chk("R8 address held", 64'(addrOut), 64'h43);
    chk("R8 no pulse paused", 64'(halfIrq), 64'd0);
    chk("R8 count frozen", 64'(evtCount), 64'(expEvt));
    loopEnA = 1'b0;
    @(negedge clk);
    chk("R8 both low held", 64'(addrOut), 64'h43);
    addrReady = 1'b0;
    loopEnA = 1'b1;
    loopEnB = 1'b1;
    @(negedge clk);
    chk("R8 resume valid", 64'(addrValid), 64'd1);
    runBeats(32'h40, 8, 3, 2, cA, cB);
    chk("R8 resume first half pulse", 64'(cA), 64'd1);
    chk("R8 resume address", 64'(addrOut), 64'h45);

    // R10: load collides with the region-end beat
    doLoad(32'h80, 16'd4);
    runBeats(32'h80, 4, 0, 3, cA, cB);
    chk("R10 at region end", 64'(addrOut), 64'h83);
    baseIn = 32'h300;
    sizeIn = 16'd4;
    loadCfg = 1'b1;
    addrReady = 1'b1;
    @(posedge clk);
    @(negedge clk);
    loadCfg = 1'b0;
    addrReady = 1'b0;
    chk("R10 no pulse on load", 64'(halfIrq), 64'd0);
    chk("R10 new base", 64'(addrOut), 64'h300);
    chk("R10 count unchanged", 64'(evtCount), 64'(expEvt));
    runBeats(32'h300, 4, 0, 4, cA, cB);
    chk("R10 sweep after load", 64'(cA + cB), 64'd2);
    chk("R9 final count", 64'(evtCount), 64'(expEvt));

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule